// File: doc/BRIEF.md
# Cascadable Dual Pulse Accumulator

The block holds two 8-bit event counters, each fed by its own pulse pin. Each pin passes through a two-flop synchroniser and a rising-edge detector. In separate mode each counter advances on its own pin's edges, but only while its channel enable is set and the timer-enable input is high.

Setting the cascade bit joins the two counters into one 16-bit counter. Counter 1 holds the high byte and counter 0 holds the low byte. The joined counter is driven only by pin 0, the pin it shares with input-capture channel 0. It ignores the per-channel enables and the timer-enable input.

When the 16-bit count rolls over from 0xFFFF to 0x0000, an overflow flag is set. The flag is cleared by writing 1 to it. An interrupt output is raised while both the flag and its enable bit are set. Software reads all state, and loads the counter bytes, through a small register port.

Top module: `pulse_acc_top`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0.
- R2: The control register is at address 0. Bit 6 is the cascade enable and bit 1 is the overflow interrupt enable; every other bit reads 0. The channel-enable register is at address 1, with bit 0 for channel 0 and bit 1 for channel 1; its other bits read 0.
- R3: In separate mode, counter n (address 4 for n=0, address 5 for n=1) increases by one for each rising edge on `pulseIn[n]` while its channel-enable bit and `timerEn` are both 1. An edge reaches the count on the third rising clock edge after the pin rises.
- R4: In separate mode, a channel does not count while its channel-enable bit is 0 or while `timerEn` is 0.
- R5: In cascade mode, {counter 1, counter 0} acts as one 16-bit counter that increases on each rising edge of `pulseIn[0]`. The low byte carries into the high byte. `pulseIn[1]` and the channel-enable bits have no effect.
- R6: In cascade mode, the counter keeps counting while `timerEn` is 0.
- R7: A cascade-mode step from 0xFFFF to 0x0000 sets the overflow flag, which is bit 1 of the flag register at address 2. The other bits of the flag register read 0.
- R8: Writing 1 to flag bit 1 clears the flag, and writing 0 leaves it unchanged. If the flag is set and cleared in the same cycle, it ends up set.
- R9: `irq` is 1 exactly when the overflow flag and the overflow interrupt enable are both 1.
- R10: A write to a counter byte loads the written value. If the write falls in the same cycle as a counted edge, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 3 | Register address |
| regWe | input | 1 | Register write strobe |
| regWdata | input | 8 | Register write data |
| regRdata | output | 8 | Register read data (combinational) |
| pulseIn | input | 2 | Asynchronous pulse pins, one per channel |
| timerEn | input | 1 | Main timer enable |
| irq | output | 1 | Overflow interrupt request |

## Verification
A vector table walks several settings of mode, channel enables and timer enable against different pulse counts on the two pins. Unequal counts on the two pins show which pin feeds which byte. Runs that drive pulses but expect zero growth separate the separate-mode gating from the cascade bypass of that gating. Directed cases preload the joined counter near 0x00FF and 0xFFFF to expose the carry and the rollover. They also line a register write up with the cycle in which an edge is counted, to show that set wins over clear for the flag and that a load wins over the increment.

// File: rtl/pulse_acc_pkg.sv
package pulse_acc_pkg;
  localparam int CNT_W  = 8;
  localparam int NCH    = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_CHEN = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_CNT0 = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_CNT1 = 3'd5;

  localparam int CASC_BIT = 6;
  localparam int OVIE_BIT = 1;
  localparam int OVF_BIT  = 1;

  typedef struct packed {
    logic [NCH-1:0]   inc;
    logic [NCH-1:0]   ld;
    logic [CNT_W-1:0] ldData;
  } acc_strobe_t;
endpackage

// File: rtl/pulse_acc_ctrl.sv
module pulse_acc_ctrl
  import pulse_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWe,
  input  logic [CNT_W-1:0]     regWdata,
  output logic [CNT_W-1:0]     regRdata,
  input  logic [NCH-1:0]       pulseIn,
  input  logic                 timerEn,
  input  logic [CNT_W-1:0]     cnt0,
  input  logic [CNT_W-1:0]     cnt1,
  output acc_strobe_t          stb,
  output logic                 irq
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic           cascEn;
  logic           ovIe;
  logic [NCH-1:0] chEn;
  logic           ovfFlag;
  logic [NCH-1:0] edgeSeen;
  logic           setOvf;
  logic           clrOvf;

  // Per-channel synchroniser followed by an edge detector
  for (genvar ch = 0; ch < NCH; ch++) begin : g_sync
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevLvl;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ   <= '0;
        prevLvl <= 1'b0;
      end else begin
        syncQ   <= {syncQ[SYNC_STAGES-2:0], pulseIn[ch]};
        prevLvl <= syncQ[SYNC_STAGES-1];
      end
    end
    assign edgeSeen[ch] = syncQ[SYNC_STAGES-1] & ~prevLvl;
  end

  // Count strobes: cascade mode overrides the per-channel gating
  always_comb begin
    stb.ldData = regWdata;
    stb.ld[0]  = regWe && (regAddr == ADDR_CNT0);
    stb.ld[1]  = regWe && (regAddr == ADDR_CNT1);
    if (cascEn) begin
      stb.inc[0] = edgeSeen[0];
      stb.inc[1] = edgeSeen[0] && (cnt0 == ALL_ONES);
    end else begin
      stb.inc[0] = edgeSeen[0] && chEn[0] && timerEn;
      stb.inc[1] = edgeSeen[1] && chEn[1] && timerEn;
    end
  end

  assign setOvf = cascEn && edgeSeen[0] && (cnt0 == ALL_ONES) && (cnt1 == ALL_ONES);
  assign clrOvf = regWe && (regAddr == ADDR_FLAG) && regWdata[OVF_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cascEn  <= 1'b0;
      ovIe    <= 1'b0;
      chEn    <= '0;
      ovfFlag <= 1'b0;
    end else begin
      if (regWe && regAddr == ADDR_CTRL) begin
        cascEn <= regWdata[CASC_BIT];
        ovIe   <= regWdata[OVIE_BIT];
      end
      if (regWe && regAddr == ADDR_CHEN) chEn <= regWdata[NCH-1:0];
      if (setOvf)      ovfFlag <= 1'b1;
      else if (clrOvf) ovfFlag <= 1'b0;
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdata[CASC_BIT] = cascEn;
        regRdata[OVIE_BIT] = ovIe;
      end
      ADDR_CHEN: regRdata[NCH-1:0] = chEn;
      ADDR_FLAG: regRdata[OVF_BIT] = ovfFlag;
      ADDR_CNT0: regRdata = cnt0;
      ADDR_CNT1: regRdata = cnt1;
      default:   regRdata = '0;
    endcase
  end

  assign irq = ovfFlag & ovIe;

  // R7: the flag only rises after the joined count was at its top value
  a_r7_ovf_source: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !$past(ovfFlag)) |-> $past(cascEn && cnt0 == ALL_ONES && cnt1 == ALL_ONES));

  // R8: a clear that does not meet a set empties the flag
  a_r8_clear: assert property (@(posedge clk) disable iff (!rstN)
    $past(clrOvf && !setOvf) |-> !ovfFlag);

  // R8: a set always leaves the flag high
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    $past(setOvf) |-> ovfFlag);
endmodule

// File: rtl/pulse_acc_dp.sv
module pulse_acc_dp
  import pulse_acc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  acc_strobe_t      stb,
  output logic [CNT_W-1:0] cnt0,
  output logic [CNT_W-1:0] cnt1
);
  logic [CNT_W-1:0] cntQ [NCH];

  for (genvar ch = 0; ch < NCH; ch++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               cntQ[ch] <= '0;
      else if (stb.ld[ch])     cntQ[ch] <= stb.ldData;
      else if (stb.inc[ch])    cntQ[ch] <= cntQ[ch] + CNT_W'(1);
    end

    // R10: a load strobe puts the written byte in the counter
    a_r10_load: assert property (@(posedge clk) disable iff (!rstN)
      $past(stb.ld[ch]) |-> cntQ[ch] == $past(stb.ldData));

    // R3: an unloaded increment moves the count by exactly one
    a_r3_step: assert property (@(posedge clk) disable iff (!rstN)
      $past(stb.inc[ch] && !stb.ld[ch]) |-> cntQ[ch] == $past(cntQ[ch]) + CNT_W'(1));

    // R4: without any strobe the count holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rstN)
      $past(!stb.inc[ch] && !stb.ld[ch]) |-> $stable(cntQ[ch]));
  end

  assign cnt0 = cntQ[0];
  assign cnt1 = cntQ[1];
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
  import pulse_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [CNT_W-1:0]  regWdata,
  output logic [CNT_W-1:0]  regRdata,
  input  logic [NCH-1:0]    pulseIn,
  input  logic              timerEn,
  output logic              irq
);
  acc_strobe_t      stb;
  logic [CNT_W-1:0] cnt0;
  logic [CNT_W-1:0] cnt1;

  pulse_acc_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .pulseIn(pulseIn),
    .timerEn(timerEn), .cnt0(cnt0), .cnt1(cnt1), .stb(stb), .irq(irq)
  );

  pulse_acc_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cnt0(cnt0), .cnt1(cnt1)
  );
endmodule

// File: tb/tb_pulse_acc_top.sv
module tb_pulse_acc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic       regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic [7:0] regRdata;
  logic [1:0] pulseIn = '0;
  logic       timerEn = 1'b0;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  pulse_acc_top dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .pulseIn(pulseIn),
    .timerEn(timerEn), .irq(irq)
  );

  always #4 clk = ~clk;

  // Vector fields: [27] cascade, [26:25] chan enables, [24] timerEn,
  // [23:20] pulses pin0, [19:16] pulses pin1, [15:8] expected cnt0, [7:0] expected cnt1
  localparam logic [27:0] VEC [6] = '{
    {1'b0, 2'b11, 1'b1, 4'd3, 4'd5, 8'd3, 8'd5},
    {1'b0, 2'b01, 1'b1, 4'd4, 4'd4, 8'd4, 8'd0},
    {1'b0, 2'b11, 1'b0, 4'd2, 4'd2, 8'd0, 8'd0},
    {1'b0, 2'b10, 1'b1, 4'd2, 4'd6, 8'd0, 8'd6},
    {1'b1, 2'b00, 1'b0, 4'd5, 4'd7, 8'd5, 8'd0},
    {1'b1, 2'b11, 1'b1, 4'd2, 4'd0, 8'd2, 8'd0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdata;
  endtask

  task automatic pulses(input int n0, input int n1);
    int n;
    n = (n0 > n1) ? n0 : n1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pulseIn = {1'(i < n1), 1'(i < n0)};
      repeat (2) @(negedge clk);
      pulseIn = 2'b00;
      repeat (2) @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  // Pin 0 rise lined up so the counted edge meets a write of (a, d)
  task automatic edgeWithWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    pulseIn[0] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
    pulseIn[0] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v);
      check("R1", v, 8'h00);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);
    rstN = 1'b1;

    // R2: unused bits read as zero
    wr(3'd0, 8'hFF); rd(3'd0, v); check("R2 ctrl", v, 8'h42);
    wr(3'd1, 8'hFF); rd(3'd1, v); check("R2 chen", v, 8'h03);
    wr(3'd0, 8'h00);

    // R3 R4 R5 R6: vector walk
    foreach (VEC[i]) begin
      wr(3'd0, {1'b0, VEC[i][27], 6'b0});
      wr(3'd1, {6'b0, VEC[i][26:25]});
      timerEn = VEC[i][24];
      wr(3'd4, 8'h00);
      wr(3'd5, 8'h00);
      pulses(int'(VEC[i][23:20]), int'(VEC[i][19:16]));
      rd(3'd4, v); check(VEC[i][27] ? "R5/R6 low byte" : "R3/R4 cnt0", v, VEC[i][15:8]);
      rd(3'd5, v); check(VEC[i][27] ? "R5/R6 high byte" : "R3/R4 cnt1", v, VEC[i][7:0]);
    end

    // R5: carry from low into high byte
    timerEn = 1'b1;
    wr(3'd0, 8'h40);
    wr(3'd5, 8'h00); wr(3'd4, 8'hFE);
    pulses(3, 0);
    rd(3'd4, v); check("R5 carry low", v, 8'h01);
    rd(3'd5, v); check("R5 carry high", v, 8'h01);

    // R7 R9: rollover sets the flag; irq follows the enable
    wr(3'd0, 8'h40);
    wr(3'd5, 8'hFF); wr(3'd4, 8'hFF);
    pulses(1, 0);
    rd(3'd4, v); check("R7 wrap low", v, 8'h00);
    rd(3'd5, v); check("R7 wrap high", v, 8'h00);
    rd(3'd2, v); check("R7 flag", v, 8'h02);
    check("R9 irq masked", {7'b0, irq}, 8'h00);
    wr(3'd0, 8'h42);
    #1 check("R9 irq on", {7'b0, irq}, 8'h01);

    // R8: write 0 keeps, write 1 clears
    wr(3'd2, 8'h00); rd(3'd2, v); check("R8 write0 keeps", v, 8'h02);
    wr(3'd2, 8'hFF); rd(3'd2, v); check("R8 write1 clears", v, 8'h00);
    #1 check("R9 irq off", {7'b0, irq}, 8'h00);

    // R8: set and clear in the same cycle leaves it set
    wr(3'd5, 8'hFF); wr(3'd4, 8'hFF);
    edgeWithWrite(3'd2, 8'h02);
    rd(3'd2, v); check("R8 set wins", v, 8'h02);
    #1 check("R9 irq with flag", {7'b0, irq}, 8'h01);
    wr(3'd2, 8'h02);

    // R10: a load meeting a counted edge wins
    wr(3'd0, 8'h00); wr(3'd1, 8'h01);
    wr(3'd4, 8'h10);
    edgeWithWrite(3'd4, 8'h55);
    rd(3'd4, v); check("R10 load wins", v, 8'h55);
    pulses(1, 0);
    rd(3'd4, v); check("R10 count after load", v, 8'h56);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule